// File: doc/BRIEF.md
# Linked-List DMA Descriptor Engine

This block is a single-channel DMA engine that moves data from memory to a peripheral under the control of a chain of descriptors held in memory. Software writes a list of four-word descriptors and places the address of the first one on `head_ptr`. Software then raises `chan_en`. The engine reads a descriptor and performs the packet of transfers that it describes. It then follows the next-pointer to the following descriptor. A zero next-pointer ends the chain. A pointer back to an earlier descriptor makes the engine cycle through the list until software drops the enable.

Reads from the source and writes to the destination both use one simple memory master port. A beat completes in any cycle in which the engine requests and `mem_ready` is high. Read data is returned in that same cycle. Source and destination can have different widths. Bytes read from the source are gathered little-endian and written at the destination width. The engine itself decides how many transfers a packet holds. The peripheral only decides when each destination burst may begin, and the engine reports the end of each burst with a one-cycle acknowledge.

Top module: `lldma_engine`

## Requirements
- R1: While idle with `chan_en` high and `head_ptr` nonzero, the engine reads the descriptor as four word beats at byte offsets 0, 4, 8 and 12 in that order: source address, destination address, next pointer, control word. A zero `head_ptr` causes no bus activity.
- R2: The control word holds the transfer count in bits [11:0], counted in source-width units. Exactly that many source reads occur per packet, and a count of zero performs no reads and no writes.
- R3: Width codes are 0 = 8 bits, 1 = 16 bits and 2 = 32 bits, with source width in control bits [19:18] and destination width in [21:20]. The same code appears on `mem_size`. Data sits in the low-order bits of `mem_rdata`/`mem_wdata`. The earliest source byte becomes the least significant byte of a destination beat.
- R4: Control bit 22 (source) and bit 23 (destination) make the respective address step by its width after each beat. When the bit is clear, that address stays fixed.
- R5: Burst length codes are in bits [14:12] (source) and [17:15] (destination), where code 0 means 1 beat and code n means 2^(n+1) beats. The first write of a destination burst is issued only while `periph_req` is high, and later beats of that burst do not wait for it. `periph_ack` pulses high in the cycle after the final beat of each burst, and a packet's last write also ends its burst.
- R6: `mem_last` marks the fourth descriptor beat, the last read of each source burst or packet, and the last write of each destination burst or packet.
- R7: After a packet, a zero next pointer stops the engine. A nonzero next pointer fetches that descriptor, so circular lists repeat indefinitely.
- R8: When control bit 31 is set, `tc_irq` pulses for one cycle after the packet's last transfer. A packet with the bit clear raises no pulse.
- R9: A `periph_req` held high never adds transfers beyond the programmed count.
- R10: A beat not yet accepted keeps its request and address stable. With `chan_en` low, the engine issues no new beat after the current one and returns to idle.
- R11: During and after reset, `mem_rd`, `mem_wr`, `periph_ack` and `tc_irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_en | input | 1 | Channel enable level |
| head_ptr | input | AW | Address of first descriptor |
| mem_rd | output | 1 | Read beat request |
| mem_wr | output | 1 | Write beat request |
| mem_addr | output | AW | Byte address of beat |
| mem_size | output | 2 | Beat width code |
| mem_wdata | output | 32 | Write data, low-order aligned |
| mem_last | output | 1 | Final beat of burst |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Beat accepted this cycle |
| periph_req | input | 1 | Peripheral ready for a burst |
| periph_ack | output | 1 | Burst-complete pulse |
| tc_irq | output | 1 | Terminal-count pulse |

## Verification
A table of single packets runs through every width combination: equal widths, narrowing (32 to 16, 32 to 8, 16 to 8) and widening (8 to 32, 8 to 16). The table also covers fixed and incrementing addresses at each end, so mistakes in byte order, address stride and burst closure each show up as distinct write-data, address or acknowledge-count mismatches. Directed cases hold the peripheral request low, pulse it for one cycle, chain two packets with the interrupt on only one of them, loop a circular list under a stalling memory and then drop the enable, and run a zero-count packet. These cases separate request gating, mid-burst independence, per-packet interrupt selection and clean stopping.

// File: rtl/lldma_pkg.sv
package lldma_pkg;

    localparam int CNT_W  = 12;
    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_MOVE,
        ST_DONE
    } eng_state_e;

    // control word layout (32 bits)
    typedef struct packed {
        logic             irq_en;     // [31]
        logic [6:0]       spare;      // [30:24]
        logic             dst_inc;    // [23]
        logic             src_inc;    // [22]
        logic [1:0]       dst_w;      // [21:20]
        logic [1:0]       src_w;      // [19:18]
        logic [2:0]       dst_burst;  // [17:15]
        logic [2:0]       src_burst;  // [14:12]
        logic [CNT_W-1:0] count;      // [11:0]
    } ctrl_word_t;

    function automatic logic [2:0] width_bytes(input logic [1:0] code);
        case (code)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [1:0] size_code(input logic [1:0] code);
        return (code == 2'd3) ? 2'd2 : code;
    endfunction

    function automatic logic [8:0] burst_beats(input logic [2:0] code);
        if (code == 3'd0) return 9'd1;
        return 9'd1 << ({1'b0, code} + 4'd1);
    endfunction

    function automatic logic [WORD_W-1:0] byte_mask(input logic [2:0] nb);
        if (nb >= 3'd4) return '1;
        return (32'd1 << {nb, 3'b000}) - 32'd1;
    endfunction

endpackage

// File: rtl/lldma_burst_ctr.sv
module lldma_burst_ctr
    import lldma_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       step,
    input  logic [2:0] len_code,
    output logic       last
);
    logic [7:0] beat_q;

    assign last = ({1'b0, beat_q} == (burst_beats(len_code) - 9'd1));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            beat_q <= '0;
        end else if (step) begin
            beat_q <= last ? 8'd0 : beat_q + 8'd1;
        end
    end
endmodule

// File: rtl/lldma_addr_gen.sv
module lldma_addr_gen #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step,
    input  logic          inc,
    input  logic [2:0]    stride,
    output logic [AW-1:0] addr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
        end else if (load) begin
            addr <= load_val;
        end else if (step && inc) begin
            addr <= addr + AW'(stride);
        end
    end
endmodule

// File: rtl/lldma_pack.sv
module lldma_pack
    import lldma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              push,
    input  logic [2:0]        push_bytes,
    input  logic [WORD_W-1:0] push_data,
    input  logic              pop,
    input  logic [2:0]        pop_bytes,
    output logic [2:0]        level,
    output logic [WORD_W-1:0] head
);
    logic [WORD_W-1:0] data_q;

    assign head = data_q & byte_mask(pop_bytes);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            data_q <= '0;
            level  <= '0;
        end else if (push) begin
            data_q <= data_q | ((push_data & byte_mask(push_bytes)) << {level, 3'b000});
            level  <= level + push_bytes;
        end else if (pop) begin
            data_q <= data_q >> {pop_bytes, 3'b000};
            level  <= level - pop_bytes;
        end
    end

    AST_PACK_BOUND: assert property (@(posedge clk) disable iff (rst)
        level <= 3'd4);                                            // R3
    AST_POP_HAS_DATA: assert property (@(posedge clk) disable iff (rst)
        pop |-> level >= pop_bytes);                               // R3
    AST_PUSH_FITS: assert property (@(posedge clk) disable iff (rst)
        push |-> ({1'b0, level} + {1'b0, push_bytes}) <= 4'd4);    // R3
endmodule

// File: rtl/lldma_engine.sv
module lldma_engine
    import lldma_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chan_en,
    input  logic [AW-1:0]     head_ptr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [AW-1:0]     mem_addr,
    output logic [1:0]        mem_size,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              mem_last,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ready,
    input  logic              periph_req,
    output logic              periph_ack,
    output logic              tc_irq
);
    localparam int DESC_WORDS = 4;
    localparam int IDX_W      = $clog2(DESC_WORDS);
    localparam logic [IDX_W-1:0] IDX_SRC  = IDX_W'(0);
    localparam logic [IDX_W-1:0] IDX_DST  = IDX_W'(1);
    localparam logic [IDX_W-1:0] IDX_NEXT = IDX_W'(2);
    localparam logic [IDX_W-1:0] IDX_CTRL = IDX_W'(DESC_WORDS - 1);

    eng_state_e        state;
    logic [IDX_W-1:0]  fidx;
    logic [AW-1:0]     desc_ptr;
    logic [AW-1:0]     next_ptr;
    ctrl_word_t        ctrl;
    logic [CNT_W-1:0]  src_left;
    logic              dst_open;

    logic [AW-1:0]     src_addr, dst_addr;
    logic [2:0]        lvl;
    logic [WORD_W-1:0] head;
    logic [2:0]        sw_b, dw_b;
    logic              rb_last, wb_last;

    logic in_move, fetch_req, want_wr, wr_req, rd_data_req, pkt_end;
    logic rd_fire, wr_fire, fetch_fire, desc_done;
    logic pkt_last_wr, wr_last, rd_last;

    assign sw_b        = width_bytes(ctrl.src_w);
    assign dw_b        = width_bytes(ctrl.dst_w);
    assign in_move     = (state == ST_MOVE);
    assign fetch_req   = (state == ST_FETCH);
    assign want_wr     = (lvl >= dw_b);
    assign wr_req      = in_move && want_wr && (dst_open || periph_req);
    assign rd_data_req = in_move && !want_wr && (src_left != '0);
    assign pkt_end     = in_move && !want_wr && (src_left == '0);

    assign rd_fire     = rd_data_req && mem_ready;
    assign wr_fire     = wr_req && mem_ready;
    assign fetch_fire  = fetch_req && mem_ready;
    assign desc_done   = fetch_fire && (fidx == IDX_CTRL);

    assign pkt_last_wr = (src_left == '0) && ((lvl - dw_b) < dw_b);
    assign wr_last     = wb_last || pkt_last_wr;
    assign rd_last     = rb_last || (src_left == CNT_W'(1));

    // bus outputs
    assign mem_rd    = fetch_req || rd_data_req;
    assign mem_wr    = wr_req;
    assign mem_addr  = fetch_req ? (desc_ptr + (AW'(fidx) << 2))
                     : (wr_req ? dst_addr : src_addr);
    assign mem_size  = fetch_req ? 2'd2
                     : (wr_req ? size_code(ctrl.dst_w) : size_code(ctrl.src_w));
    assign mem_wdata = wr_req ? head : '0;
    assign mem_last  = fetch_req ? (fidx == IDX_CTRL)
                     : (wr_req ? wr_last : (rd_data_req && rd_last));

    lldma_pack u_pack (
        .clk        (clk),
        .rst        (rst),
        .clear      (desc_done),
        .push       (rd_fire),
        .push_bytes (sw_b),
        .push_data  (mem_rdata),
        .pop        (wr_fire),
        .pop_bytes  (dw_b),
        .level      (lvl),
        .head       (head)
    );

    lldma_addr_gen #(.AW(AW)) u_src_addr (
        .clk      (clk),
        .rst      (rst),
        .load     (fetch_fire && (fidx == IDX_SRC)),
        .load_val (mem_rdata[AW-1:0]),
        .step     (rd_fire),
        .inc      (ctrl.src_inc),
        .stride   (sw_b),
        .addr     (src_addr)
    );

    lldma_addr_gen #(.AW(AW)) u_dst_addr (
        .clk      (clk),
        .rst      (rst),
        .load     (fetch_fire && (fidx == IDX_DST)),
        .load_val (mem_rdata[AW-1:0]),
        .step     (wr_fire),
        .inc      (ctrl.dst_inc),
        .stride   (dw_b),
        .addr     (dst_addr)
    );

    lldma_burst_ctr u_rd_burst (
        .clk      (clk),
        .rst      (rst),
        .clear    (desc_done || (rd_fire && (src_left == CNT_W'(1)))),
        .step     (rd_fire),
        .len_code (ctrl.src_burst),
        .last     (rb_last)
    );

    lldma_burst_ctr u_wr_burst (
        .clk      (clk),
        .rst      (rst),
        .clear    (desc_done || (wr_fire && pkt_last_wr)),
        .step     (wr_fire),
        .len_code (ctrl.dst_burst),
        .last     (wb_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            fidx       <= '0;
            desc_ptr   <= '0;
            next_ptr   <= '0;
            ctrl       <= '0;
            src_left   <= '0;
            dst_open   <= 1'b0;
            periph_ack <= 1'b0;
            tc_irq     <= 1'b0;
        end else begin
            periph_ack <= 1'b0;
            tc_irq     <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (chan_en && (head_ptr != '0)) begin
                        desc_ptr <= head_ptr;
                        fidx     <= '0;
                        state    <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (mem_ready) begin
                        fidx <= fidx + IDX_W'(1);
                        if (fidx == IDX_NEXT) begin
                            next_ptr <= mem_rdata[AW-1:0];
                        end
                        if (fidx == IDX_CTRL) begin
                            ctrl     <= ctrl_word_t'(mem_rdata);
                            src_left <= mem_rdata[CNT_W-1:0];
                            dst_open <= 1'b0;
                            state    <= ST_MOVE;
                        end
                    end
                end
                ST_MOVE: begin
                    if (rd_fire) begin
                        src_left <= src_left - CNT_W'(1);
                    end
                    if (wr_req) begin
                        dst_open <= wr_fire ? !wr_last : 1'b1;
                    end
                    if (wr_fire) begin
                        periph_ack <= wr_last;
                    end
                    if (pkt_end) begin
                        tc_irq <= ctrl.irq_en;
                        if (next_ptr == '0) begin
                            state <= ST_DONE;
                        end else begin
                            desc_ptr <= next_ptr;
                            fidx     <= '0;
                            state    <= ST_FETCH;
                        end
                    end
                end
                default: ;
            endcase
            if (!chan_en && !((mem_rd || mem_wr) && !mem_ready)) begin
                state    <= ST_IDLE;
                dst_open <= 1'b0;
            end
        end
    end

    AST_RW_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));                                          // R10
    AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_rd || mem_wr) && !mem_ready |=>
            (mem_rd || mem_wr) && $stable(mem_addr) && $stable(mem_wr)); // R10
    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (rst)
        !chan_en && (!(mem_rd || mem_wr) || mem_ready) |=> !mem_rd && !mem_wr); // R10
    AST_BURST_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        mem_wr && !dst_open |-> periph_req);                           // R5
    AST_ACK_AFTER_BEAT: assert property (@(posedge clk) disable iff (rst)
        periph_ack |-> $past(mem_wr && mem_ready));                    // R5
    AST_IRQ_AFTER_PACKET: assert property (@(posedge clk) disable iff (rst)
        tc_irq |-> $past(state == ST_MOVE && !mem_rd && !mem_wr));     // R8
    AST_FETCH_WORD: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FETCH) |-> mem_rd && mem_size == 2'd2);           // R1
endmodule

// File: tb/lldma_engine_bench.sv
module lldma_engine_bench;
    localparam int AW = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        chan_en = 1'b0;
    logic [31:0] head_ptr = '0;
    logic        mem_rd, mem_wr, mem_last, periph_ack, tc_irq;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [1:0]  mem_size;
    logic        mem_ready;
    logic        periph_req = 1'b1;
    logic        stall = 1'b0;
    logic        tick = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    lldma_engine #(.AW(AW)) u_lldma_engine (
        .clk(clk), .rst(rst), .chan_en(chan_en), .head_ptr(head_ptr),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_last(mem_last),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .periph_req(periph_req), .periph_ack(periph_ack), .tc_irq(tc_irq)
    );

    // memory model
    logic [7:0] mem [0:1023];
    int nbytes;
    always_ff @(posedge clk) tick <= ~tick;
    assign mem_ready = stall ? tick : 1'b1;
    assign nbytes = (mem_size == 2'd0) ? 1 : (mem_size == 2'd1) ? 2 : 4;
    always_comb begin
        mem_rdata = '0;
        for (int i = 0; i < 4; i++)
            if (i < nbytes) mem_rdata[i*8 +: 8] = mem[10'(mem_addr[9:0] + 10'(i))];
    end

    // monitor
    int wr_cnt = 0, rd_cnt = 0, rdlast_cnt = 0, ack_cnt = 0, irq_cnt = 0, f_cnt = 0;
    logic [31:0] wl_addr [0:255];
    logic [31:0] wl_data [0:255];
    logic [31:0] fl_addr [0:255];
    always @(negedge clk) begin
        if (!rst) begin
            if (mem_wr && mem_ready) begin
                wl_addr[wr_cnt[7:0]] = mem_addr;
                wl_data[wr_cnt[7:0]] = mem_wdata;
                wr_cnt++;
            end
            if (mem_rd && mem_ready) begin
                if (mem_addr >= 32'h200) begin
                    rd_cnt++;
                    if (mem_last) rdlast_cnt++;
                end else begin
                    fl_addr[f_cnt[7:0]] = mem_addr;
                    f_cnt++;
                end
            end
            if (periph_ack) ack_cnt++;
            if (tc_irq) irq_cnt++;
        end
    end

    int total = 0, bad = 0;
    int b_wr, b_rd, b_rl, b_ack, b_irq, b_f;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic snap();
        b_wr = wr_cnt; b_rd = rd_cnt; b_rl = rdlast_cnt;
        b_ack = ack_cnt; b_irq = irq_cnt; b_f = f_cnt;
    endtask

    task automatic put_word(input logic [31:0] a, input logic [31:0] d);
        for (int i = 0; i < 4; i++) mem[10'(a[9:0] + 10'(i))] = d[i*8 +: 8];
    endtask

    task automatic put_desc(input logic [31:0] base, input logic [31:0] s,
                            input logic [31:0] d, input logic [31:0] nx,
                            input logic [31:0] c);
        put_word(base, s); put_word(base + 4, d);
        put_word(base + 8, nx); put_word(base + 12, c);
    endtask

    function automatic logic [31:0] mk_ctrl(input logic [11:0] cnt, input logic [2:0] sb,
        input logic [2:0] db, input logic [1:0] sw, input logic [1:0] dw,
        input logic si, input logic di, input logic irq);
        return {irq, 7'd0, di, si, dw, sw, db, sb, cnt};
    endfunction

    task automatic wait_irq(input int target, input int limit, input string req);
        int n = 0;
        while ((irq_cnt - b_irq) < target && n < limit) begin
            @(negedge clk); n++;
        end
        chk((irq_cnt - b_irq) >= target, req, "interrupt wait timeout", irq_cnt - b_irq, target);
    endtask

    // {sw[36:35], dw[34:33], count[32:21], si[20], di[19], db[18:16], nwr[15:8], nack[7:0]}
    localparam logic [36:0] VEC [6] = '{
        {2'd2, 2'd2, 12'd6,  1'b1, 1'b1, 3'd0, 8'd6,  8'd6 },
        {2'd2, 2'd1, 12'd5,  1'b1, 1'b1, 3'd1, 8'd10, 8'd3 },
        {2'd0, 2'd2, 12'd12, 1'b1, 1'b1, 3'd0, 8'd3,  8'd3 },
        {2'd1, 2'd0, 12'd7,  1'b1, 1'b0, 3'd0, 8'd14, 8'd14},
        {2'd0, 2'd1, 12'd10, 1'b1, 1'b1, 3'd1, 8'd5,  8'd2 },
        {2'd2, 2'd0, 12'd3,  1'b0, 1'b1, 3'd2, 8'd12, 8'd2 }
    };
    localparam logic [31:0] DST = 32'h8000_0040;

    logic [7:0] strm [0:63];

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 8'(i * 7 + 3);
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(!mem_rd && !mem_wr && !periph_ack && !tc_irq, "R11", "outputs in reset",
            {mem_rd, mem_wr, periph_ack, tc_irq}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!mem_rd && !mem_wr && !periph_ack && !tc_irq, "R11", "outputs after reset",
            {mem_rd, mem_wr, periph_ack, tc_irq}, 0);

        // R1 zero head pointer gives no activity
        head_ptr = 32'h0; chan_en = 1'b1; snap();
        repeat (10) @(negedge clk);
        chk((f_cnt - b_f) == 0 && !mem_rd, "R1", "zero head reads", f_cnt - b_f, 0);
        chan_en = 1'b0; repeat (2) @(negedge clk);
        head_ptr = 32'h100;

        // table of packets
        for (int v = 0; v < 6; v++) begin
            logic [1:0] sw_c, dw_c; logic [11:0] cnt; logic si, di; logic [2:0] db;
            int nwr, nack, swb, dwb, data_bad, addr_bad;
            sw_c = VEC[v][36:35]; dw_c = VEC[v][34:33]; cnt = VEC[v][32:21];
            si = VEC[v][20]; di = VEC[v][19]; db = VEC[v][18:16];
            nwr = int'(VEC[v][15:8]); nack = int'(VEC[v][7:0]);
            swb = (sw_c == 0) ? 1 : (sw_c == 1) ? 2 : 4;
            dwb = (dw_c == 0) ? 1 : (dw_c == 1) ? 2 : 4;
            for (int j = 0; j < int'(cnt); j++)
                for (int b = 0; b < swb; b++)
                    strm[6'(j*swb + b)] = mem[10'(32'h200 + (si ? j*swb : 0) + b)];
            put_desc(32'h100, 32'h200, DST, 32'h0,
                     mk_ctrl(cnt, 3'd0, db, sw_c, dw_c, si, di, 1'b1));
            snap(); chan_en = 1'b1;
            wait_irq(1, 3000, "R8");
            repeat (3) @(negedge clk);
            chk((wr_cnt - b_wr) == nwr, "R9", "write count", wr_cnt - b_wr, nwr);
            chk((rd_cnt - b_rd) == int'(cnt), "R2", "source read count", rd_cnt - b_rd, cnt);
            chk((ack_cnt - b_ack) == nack, "R5", "ack count", ack_cnt - b_ack, nack);
            data_bad = 0; addr_bad = 0;
            for (int k = 0; k < nwr; k++) begin
                logic [31:0] ed;
                ed = '0;
                for (int b = 0; b < dwb; b++) ed[b*8 +: 8] = strm[6'(k*dwb + b)];
                if (wl_data[8'(b_wr + k)] !== ed) data_bad++;
                if (wl_addr[8'(b_wr + k)] !== DST + (di ? 32'(k*dwb) : 32'd0)) addr_bad++;
            end
            chk(data_bad == 0, "R3", "write data mismatches", data_bad, 0);
            chk(addr_bad == 0, "R4", "write address mismatches", addr_bad, 0);
            if (v == 0) begin
                chk(fl_addr[8'(b_f)] == 32'h100 && fl_addr[8'(b_f+1)] == 32'h104 &&
                    fl_addr[8'(b_f+2)] == 32'h108 && fl_addr[8'(b_f+3)] == 32'h10C,
                    "R1", "descriptor read order", fl_addr[8'(b_f+3)], 32'h10C);
            end
            chk(!mem_rd && !mem_wr, "R7", "stopped on zero next", {mem_rd, mem_wr}, 0);
            chan_en = 1'b0; repeat (3) @(negedge clk);
        end

        // two-packet chain, interrupt only on second, source bursts of 4
        put_desc(32'h100, 32'h200, DST, 32'h140,
                 mk_ctrl(12'd6, 3'd1, 3'd0, 2'd2, 2'd2, 1'b1, 1'b1, 1'b0));
        put_desc(32'h140, 32'h240, DST, 32'h0,
                 mk_ctrl(12'd2, 3'd0, 3'd0, 2'd2, 2'd2, 1'b1, 1'b1, 1'b1));
        snap(); chan_en = 1'b1;
        wait_irq(1, 3000, "R7");
        repeat (10) @(negedge clk);
        chk((irq_cnt - b_irq) == 1, "R8", "irq only on flagged packet", irq_cnt - b_irq, 1);
        chk((wr_cnt - b_wr) == 8, "R7", "chained write count", wr_cnt - b_wr, 8);
        chk((rdlast_cnt - b_rl) == 4, "R6", "read last markers", rdlast_cnt - b_rl, 4);
        chan_en = 1'b0; repeat (3) @(negedge clk);

        // zero-count packet
        put_desc(32'h100, 32'h200, DST, 32'h0,
                 mk_ctrl(12'd0, 3'd0, 3'd0, 2'd2, 2'd2, 1'b1, 1'b1, 1'b1));
        snap(); chan_en = 1'b1;
        wait_irq(1, 200, "R2");
        repeat (3) @(negedge clk);
        chk((rd_cnt - b_rd) == 0 && (wr_cnt - b_wr) == 0, "R2", "zero count transfers",
            (rd_cnt - b_rd) + (wr_cnt - b_wr), 0);
        chan_en = 1'b0; repeat (3) @(negedge clk);

        // request gating: bursts of 4 words, count 8
        periph_req = 1'b0;
        put_desc(32'h100, 32'h200, DST, 32'h0,
                 mk_ctrl(12'd8, 3'd0, 3'd1, 2'd2, 2'd2, 1'b1, 1'b1, 1'b1));
        snap(); chan_en = 1'b1;
        repeat (30) @(negedge clk);
        chk((wr_cnt - b_wr) == 0, "R5", "no write without request", wr_cnt - b_wr, 0);
        periph_req = 1'b1; @(negedge clk); periph_req = 1'b0;
        repeat (30) @(negedge clk);
        chk((wr_cnt - b_wr) == 4, "R5", "one burst per request", wr_cnt - b_wr, 4);
        chk((ack_cnt - b_ack) == 1, "R5", "ack after burst", ack_cnt - b_ack, 1);
        periph_req = 1'b1;
        wait_irq(1, 3000, "R5");
        repeat (3) @(negedge clk);
        chk((wr_cnt - b_wr) == 8, "R9", "exact count with request high", wr_cnt - b_wr, 8);
        chan_en = 1'b0; repeat (3) @(negedge clk);

        // circular list with stalling memory, then disable
        stall = 1'b1;
        put_desc(32'h100, 32'h200, DST, 32'h140,
                 mk_ctrl(12'd3, 3'd0, 3'd0, 2'd2, 2'd2, 1'b1, 1'b1, 1'b1));
        put_desc(32'h140, 32'h240, DST, 32'h100,
                 mk_ctrl(12'd2, 3'd0, 3'd0, 2'd2, 2'd1, 1'b1, 1'b1, 1'b1));
        snap(); chan_en = 1'b1;
        wait_irq(3, 4000, "R7");
        chk((irq_cnt - b_irq) >= 3, "R7", "circular list repeats", irq_cnt - b_irq, 3);
        chan_en = 1'b0;
        repeat (4) @(negedge clk);
        begin
            int busy = 0;
            snap();
            for (int i = 0; i < 30; i++) begin
                @(negedge clk);
                if (mem_rd || mem_wr) busy++;
            end
            chk(busy == 0 && (wr_cnt - b_wr) == 0, "R10", "idle after disable", busy, 0);
        end
        stall = 1'b0;

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule